// File: doc/BRIEF.md
# ADC Capture Initialization Sequencer

This block brings a multi-channel ADC capture path out of reset and puts it back through initialization whenever its operating conditions change. It runs on a fixed control clock. Three events start a sequence: a change in the clock-source selection byte, a forced request, and a rising IO-enable flag. Only the IO-enable event also asks the converters to reset their registers. Each sequence holds the capture path in reset for a fixed number of cycles. It then waits for a run of consecutive cycles with the PLL locked, runs a calibration interval, and finally raises the done flag.

While the sequence is complete, the block watches for faults. Each ADC has its own sampling-window-too-narrow flag, and any pulse on one sets a sticky per-ADC error. Any cycle without PLL lock sets a sticky unlock flag. From that cycle on, the sample-domain clock enable stays low. Every sticky flag is cleared by the next re-initialization. A trigger that arrives while a sequence is running restarts it from the reset step.

Top module: `adc_init_seq`

## Requirements
- R1: A change of `clk_sel` from its value in the previous cycle starts a new sequence, with no other request needed.
- R2: A high `force_init` starts a new sequence, and `adc_reg_reset` stays low for that whole sequence.
- R3: A rising edge of `io_enable` starts a new sequence, and `adc_reg_reset` is high for exactly RESET_CYCLES cycles during it. Holding `io_enable` high, or lowering it, starts nothing.
- R4: `init_done` is low in the cycle that follows the clock edge at which a trigger is sampled. This is within 4 control-clock cycles (100 ns at 40 MHz).
- R5: With the PLL locked throughout, `init_done` rises exactly RESET_CYCLES + LOCK_WAIT_CYCLES + CAL_CYCLES cycles after the triggering edge. `capture_rst` is high for the whole sequence and low once it is done.
- R6: A cycle without PLL lock during the settle wait restarts the wait. The wait needs LOCK_WAIT_CYCLES consecutive locked cycles.
- R7: A trigger during a running sequence restarts it from the reset step, and the full sequence length is counted from the new trigger.
- R8: `adc_err[i]` sets when `win_err[i]` is high while the sequence is complete. It then stays set until the next trigger clears it. `win_err` has no effect while a sequence is running.
- R9: `pll_unlocked` sets when `pll_locked` is low while the sequence is complete. It then stays set until the next trigger clears it.
- R10: `sample_ce` is high only when `init_done` and `pll_locked` are both high and `pll_unlocked` is clear.
- R11: After reset, `init_done`, `adc_err`, `pll_unlocked` and `sample_ce` are low and `capture_rst` is high. The block stays idle until a trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_init | input | 1 | Forced re-initialization request |
| clk_sel | input | SEL_W | Clock-source selection byte |
| io_enable | input | 1 | IO enable; rising edge starts a sequence and register reset |
| pll_locked | input | 1 | PLL lock indication |
| win_err | input | NUM_ADC | Per-ADC sampling-window-too-narrow flags |
| init_done | output | 1 | Initialization complete |
| adc_err | output | NUM_ADC | Sticky per-ADC window errors |
| pll_unlocked | output | 1 | Sticky lock-loss flag |
| capture_rst | output | 1 | Reset to the capture path |
| adc_reg_reset | output | 1 | Request to reset ADC registers |
| sample_ce | output | 1 | Sample-domain clock enable |

## Verification
The bench sweeps all three trigger kinds against lock dropouts of several lengths, placed at several offsets in the settle wait. In each run it compares the exact cycle at which done rises with the sum computed from the parameters. A design that kept its settle count across a dropout would finish too early. A design that raised the register-reset request for every trigger, or for the wrong number of cycles, is caught by a count of the cycles in which that request is high. The bench also retriggers in the middle of a sequence, which catches a design that ignores the retrigger or resumes where it stopped. It pulses fault inputs before and after completion, which catches errors that are not sticky, errors set during a sequence, and errors that survive a re-initialization.

// File: rtl/adc_init_seq.sv
module adc_init_seq #(
  parameter int NUM_ADC          = 2,
  parameter int SEL_W            = 8,
  parameter int RESET_CYCLES     = 4,
  parameter int LOCK_WAIT_CYCLES = 40_000_000,
  parameter int CAL_CYCLES       = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_init,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               io_enable,
  input  logic               pll_locked,
  input  logic [NUM_ADC-1:0] win_err,
  output logic               init_done,
  output logic [NUM_ADC-1:0] adc_err,
  output logic               pll_unlocked,
  output logic               capture_rst,
  output logic               adc_reg_reset,
  output logic               sample_ce
);
  localparam int MAX_A = (RESET_CYCLES > CAL_CYCLES) ? RESET_CYCLES : CAL_CYCLES;
  localparam int MAX_C = (MAX_A > LOCK_WAIT_CYCLES) ? MAX_A : LOCK_WAIT_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [4:0] {
    IDLE_DONE    = 5'b00001,
    RESET_ASSERT = 5'b00010,
    WAIT_LOCK    = 5'b00100,
    CALIBRATE    = 5'b01000,
    DONE         = 5'b10000
  } state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [SEL_W-1:0]   sel_q;
  logic               io_q;
  logic               wipe_q;

  wire io_rise = io_enable & ~io_q;
  wire trig    = force_init | io_rise | (clk_sel != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q        <= clk_sel;
      io_q         <= 1'b0;
      st           <= IDLE_DONE;
      cnt          <= '0;
      wipe_q       <= 1'b0;
      adc_err      <= '0;
      pll_unlocked <= 1'b0;
    end else begin
      sel_q <= clk_sel;
      io_q  <= io_enable;
      if (trig) begin
        st           <= RESET_ASSERT;
        cnt          <= '0;
        wipe_q       <= io_rise;
        adc_err      <= '0;
        pll_unlocked <= 1'b0;
      end else begin
        unique case (st)
          RESET_ASSERT:
            if (cnt == CNT_W'(RESET_CYCLES - 1)) begin
              st  <= WAIT_LOCK;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          WAIT_LOCK:
            if (!pll_locked) cnt <= '0;
            else if (cnt == CNT_W'(LOCK_WAIT_CYCLES - 1)) begin
              st  <= CALIBRATE;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          CALIBRATE:
            if (cnt == CNT_W'(CAL_CYCLES - 1)) begin
              st  <= DONE;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          DONE: begin
            adc_err <= adc_err | win_err;
            if (!pll_locked) pll_unlocked <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign init_done     = (st == DONE);
  assign capture_rst   = ~init_done;
  assign adc_reg_reset = (st == RESET_ASSERT) & wipe_q;
  assign sample_ce     = init_done & pll_locked & ~pll_unlocked;

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1); // R7
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !init_done); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> ((adc_err & $past(adc_err)) == $past(adc_err))); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (adc_err == '0) && !pll_unlocked); // R9
  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_unlocked && !trig) |=> pll_unlocked); // R9
  AST_CE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |-> !sample_ce); // R10
  AST_WIPE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reg_reset |-> capture_rst && !init_done); // R3
endmodule

// File: tb/adc_init_seq_tb.sv
module adc_init_seq_tb_top;
  localparam int CLK_PERIOD = 25;
  localparam int NA = 2;
  localparam int RC = 3;
  localparam int LC = 5;
  localparam int CC = 4;
  localparam int TOTAL = RC + LC + CC;

  logic clk = 0, rst_n = 0, force_init = 0, io_enable = 0, pll_locked = 1;
  logic [7:0] clk_sel = 8'h00;
  logic [NA-1:0] win_err = '0;
  logic init_done, pll_unlocked, capture_rst, adc_reg_reset, sample_ce;
  logic [NA-1:0] adc_err;
  int checks = 0, errors = 0, wipe_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_init_seq #(.NUM_ADC(NA), .SEL_W(8), .RESET_CYCLES(RC),
                 .LOCK_WAIT_CYCLES(LC), .CAL_CYCLES(CC)) dut_i (
    .clk(clk), .rst_n(rst_n), .force_init(force_init), .clk_sel(clk_sel),
    .io_enable(io_enable), .pll_locked(pll_locked), .win_err(win_err),
    .init_done(init_done), .adc_err(adc_err), .pll_unlocked(pll_unlocked),
    .capture_rst(capture_rst), .adc_reg_reset(adc_reg_reset), .sample_ce(sample_ce));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // kind 0: select change (R1), 1: force (R2), 2: io rise (R3)
  task automatic start_seq(input int kind);
    if (kind == 2) begin io_enable = 0; tick(); io_enable = 1; end
    else if (kind == 1) force_init = 1;
    else clk_sel = clk_sel + 8'd1;
    tick();
    force_init = 0;
    check("R4 done low after trigger", init_done, 0);
    wipe_cnt = adc_reg_reset;
  endtask

  task automatic measure(input int o, input int d, input int exp, input string tag);
    int n = 0;
    while (!init_done && n < 200) begin
      tick(); n++;
      if (d > 0 && n == RC + o) pll_locked = 0;
      if (d > 0 && n == RC + o + d) pll_locked = 1;
      if (!init_done) begin
        wipe_cnt += adc_reg_reset;
        if (!capture_rst) check({tag, " capture_rst during seq"}, 0, 1);
      end
    end
    check(tag, n, exp);
    check("R5 capture_rst low when done", capture_rst, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R11 done after reset", init_done, 0);
    check("R11 capture_rst after reset", capture_rst, 1);
    check("R11 adc_err after reset", adc_err, 0);
    check("R11 unlock after reset", pll_unlocked, 0);
    check("R11 ce after reset", sample_ce, 0);
    repeat (6) tick();
    check("R11 stays idle", init_done, 0);

    for (int k = 0; k < 3; k++)
      for (int o = 0; o < 4; o++)
        for (int d = 0; d < 4; d++) begin
          start_seq(k);
          measure(o, d, TOTAL + d + ((d > 0) ? o : 0), (d > 0) ? "R6 lock restart" : "R5 length");
          check(k == 2 ? "R3 wipe cycles" : "R2 no wipe", wipe_cnt, k == 2 ? RC : 0);
          check("R10 ce when done", sample_ce, 1);
        end

    io_enable = 0; tick(); tick();
    check("R3 io fall no trigger", init_done, 1);
    repeat (4) tick();
    check("R3 io high no trigger", init_done, 1);

    for (int m = 1; m < TOTAL; m += 2) begin
      start_seq(0);
      repeat (m - 1) tick();
      start_seq(1);
      measure(0, 0, TOTAL, "R7 restart length");
    end

    start_seq(1);
    win_err = 2'b11; tick(); win_err = '0;
    measure(0, 0, TOTAL - 1, "R5 length with win_err");
    check("R8 win_err ignored in seq", adc_err, 0);
    win_err = 2'b01; tick(); win_err = '0;
    check("R8 err set", adc_err, 1);
    repeat (3) tick();
    check("R8 err sticky", adc_err, 1);
    win_err = 2'b10; tick(); win_err = '0;
    check("R8 err second bit", adc_err, 3);

    pll_locked = 0; #1;
    check("R10 ce drops with lock", sample_ce, 0);
    tick(); pll_locked = 1;
    check("R9 unlock set", pll_unlocked, 1);
    repeat (3) tick();
    check("R9 unlock sticky", pll_unlocked, 1);
    check("R10 ce withheld after unlock", sample_ce, 0);
    check("R9 done held", init_done, 1);

    start_seq(1);
    check("R8 err cleared", adc_err, 0);
    check("R9 unlock cleared", pll_unlocked, 0);
    measure(0, 0, TOTAL, "R1 final length");
    check("R10 ce restored", sample_ce, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule